// File: doc/BRIEF.md
# Condition Code Register Unit

This block keeps the 8-bit flag register of a small CPU whose ALU works on bytes and on 16-bit words. Each cycle it may be handed one operation: an opcode, the size, both operands, the result the ALU already produced, a bit index and an immediate byte. From these it works out the new half-carry, negative, zero, overflow and carry flags. It does not repeat the datapath arithmetic. Instead it recovers carries and borrows from the operand and result bits at the positions that matter.

The carry flag has three jobs. It is the arithmetic carry or borrow, the bit lost by a one-place shift, and a one-bit accumulator for bit operations. The register can also be written as a whole from the immediate byte, or combined with it by AND, OR or XOR. Every change lands on the clock edge that samples the operation, and the register value is always visible on the output so software can store it.

The interrupt mask sits at bit 7 and is set by reset. The remaining bits have no reset and keep whatever they held. Bit 5 is the half-carry flag. Bits 6 and 4 are plain storage bits that only the whole-register operations change.

Top module: `ccr_unit`

## Requirements
- R1: While `rst_n` is low, bit 7 (I, also on `flag_i_o`) reads 1. Bits 6..0 keep the values they held before reset.
- R2: For the byte form (`op_word_i`=0) of ADD(1), ADDX(2), SUB(3), SUBX(4), CMP(5) and NEG(6), bit 5 (H) is set to the carry (add) or borrow (others) out of bit 3 and cleared otherwise. NEG is handled as 0 minus `opnd_a_i`. ADDX and SUBX include the current C as carry or borrow in.
- R3: For the word form (`op_word_i`=1) of the same codes, H is the carry or borrow out of bit 11, and N, V and C are taken at bit 15 instead of bit 7.
- R4: For codes 1 to 8, bit 3 (N) copies the result MSB (bit 7 byte, bit 15 word). Bit 2 (Z) is 1 exactly when the result's low byte (byte) or all 16 bits (word) are zero.
- R5: For codes 1 to 6, bit 1 (V) is 1 on signed overflow. For add, that is equal operand signs with a result sign that differs. For subtract, compare and negate, that is different operand signs with a result sign that differs from the first operand.
- R6: For codes 1 to 6, bit 0 (C) is the carry (add) or borrow (subtract, compare, negate) out of the MSB.
- R7: Shift left SHL(7) loads C with the operand MSB, and shift right SHR(8) loads C with operand bit 0. Both clear V and leave H, I and bits 6 and 4 unchanged.
- R8: With b = `opnd_a_i[bit_sel_i]`, BLD(9) sets C=b, BAND(10) sets C=C&b, BOR(11) sets C=C|b and BXOR(12) sets C=C^b. Bits 7..1 stay unchanged.
- R9: LDC(13) writes the register with the immediate. ANDC(14), ORC(15) and XORC(16) write the register combined with the immediate by AND, OR or XOR. All eight bits are written, I included.
- R10: When `op_valid_i` is 0, or the code is NOP(0) or 17..31, the register does not change. Bits 6 and 4 change only through codes 13 to 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the I bit |
| op_valid_i | input | 1 | An operation is presented this cycle |
| op_code_i | input | 5 | Operation code (see requirements) |
| op_word_i | input | 1 | 1 = 16-bit operation, 0 = byte |
| opnd_a_i | input | 16 | First operand (shift source, bit-operation source) |
| opnd_b_i | input | 16 | Second operand |
| result_i | input | 16 | Result produced by the datapath |
| imm_i | input | 8 | Immediate mask or load value |
| bit_sel_i | input | 4 | Bit index into `opnd_a_i` for bit operations |
| ccr_o | output | 8 | Current register value |
| flag_i_o | output | 1 | Interrupt mask bit |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Carry flag |

## Verification
The bench builds the unit with its default widths: a 16-bit word, an 8-bit byte and a 4-bit nibble. This places the half-carry taps at bits 3 and 11 and lets both operation sizes run through the same flag logic. With these values, every bit index of a word can be selected for the bit-accumulator operations. The bench's wide-integer arithmetic can also reach the carry and overflow boundaries at 0x7F/0xFF and at 0x7FFF/0xFFFF directly, next to random operand mixes.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int CCR_W = 8;
  localparam int POS_I  = 7;
  localparam int POS_UI = 6;
  localparam int POS_H  = 5;
  localparam int POS_U  = 4;
  localparam int POS_N  = 3;
  localparam int POS_Z  = 2;
  localparam int POS_V  = 1;
  localparam int POS_C  = 0;

  typedef enum logic [4:0] {
    OP_NOP  = 5'd0,
    OP_ADD  = 5'd1,
    OP_ADDX = 5'd2,
    OP_SUB  = 5'd3,
    OP_SUBX = 5'd4,
    OP_CMP  = 5'd5,
    OP_NEG  = 5'd6,
    OP_SHL  = 5'd7,
    OP_SHR  = 5'd8,
    OP_BLD  = 5'd9,
    OP_BAND = 5'd10,
    OP_BOR  = 5'd11,
    OP_BXOR = 5'd12,
    OP_LDC  = 5'd13,
    OP_ANDC = 5'd14,
    OP_ORC  = 5'd15,
    OP_XORC = 5'd16
  } ccr_op_e;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic v;
    logic c;
  } arith_flags_t;
endpackage

// File: rtl/ccr_arith_flags.sv
module ccr_arith_flags
  import ccr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              op_word_i,
  input  logic              is_sub_i,
  input  logic              is_neg_i,
  input  logic [DATA_W-1:0] opnd_a_i,
  input  logic [DATA_W-1:0] opnd_b_i,
  input  logic [DATA_W-1:0] result_i,
  output arith_flags_t      flags_o
);
  localparam int W_MSB = DATA_W - 1;
  localparam int B_MSB = BYTE_W - 1;
  localparam int B_HC  = NIB_W - 1;
  localparam int W_HC  = DATA_W - NIB_W - 1;

  // carry out of bit k of a+b(+cin), recovered from operand and result bits
  function automatic logic carry_at(input logic ak, input logic bk, input logic rk);
    return (ak & bk) | ((ak | bk) & ~rk);
  endfunction

  // borrow out of bit k of a-b(-bin)
  function automatic logic borrow_at(input logic ak, input logic bk, input logic rk);
    return (~ak & bk) | ((~ak | bk) & rk);
  endfunction

  function automatic logic ovf_of(input logic sub, input logic am, input logic bm,
                                  input logic rm);
    if (sub) return (am ^ bm) & (rm ^ am);
    else     return ~(am ^ bm) & (rm ^ am);
  endfunction

  logic [DATA_W-1:0] src_a, src_b;
  logic a_hc, b_hc, r_hc, a_m, b_m, r_m;
  logic hc_w, cy_w, ov_w, zero_w;

  assign src_a = is_neg_i ? '0 : opnd_a_i;
  assign src_b = is_neg_i ? opnd_a_i : opnd_b_i;

  assign a_hc = op_word_i ? src_a[W_HC]      : src_a[B_HC];
  assign b_hc = op_word_i ? src_b[W_HC]      : src_b[B_HC];
  assign r_hc = op_word_i ? result_i[W_HC]   : result_i[B_HC];
  assign a_m  = op_word_i ? src_a[W_MSB]     : src_a[B_MSB];
  assign b_m  = op_word_i ? src_b[W_MSB]     : src_b[B_MSB];
  assign r_m  = op_word_i ? result_i[W_MSB]  : result_i[B_MSB];

  assign hc_w   = is_sub_i ? borrow_at(a_hc, b_hc, r_hc) : carry_at(a_hc, b_hc, r_hc);
  assign cy_w   = is_sub_i ? borrow_at(a_m, b_m, r_m)    : carry_at(a_m, b_m, r_m);
  assign ov_w   = ovf_of(is_sub_i, a_m, b_m, r_m);
  assign zero_w = op_word_i ? (result_i == '0) : (result_i[B_MSB:0] == '0);

  assign flags_o.h = hc_w;
  assign flags_o.n = r_m;
  assign flags_o.z = zero_w;
  assign flags_o.v = ov_w;
  assign flags_o.c = cy_w;
endmodule

// File: rtl/ccr_carry_path.sv
module ccr_carry_path
  import ccr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  ccr_op_e                     op_i,
  input  logic                        op_word_i,
  input  logic [DATA_W-1:0]           opnd_a_i,
  input  logic [$clog2(DATA_W)-1:0]   bit_sel_i,
  input  logic                        c_q_i,
  output logic                        c_next_o
);
  localparam int W_MSB = DATA_W - 1;
  localparam int B_MSB = BYTE_W - 1;

  logic msb_out, lsb_out, sel_bit;

  assign msb_out = op_word_i ? opnd_a_i[W_MSB] : opnd_a_i[B_MSB];
  assign lsb_out = opnd_a_i[0];
  assign sel_bit = opnd_a_i[bit_sel_i];

  always_comb begin
    unique case (op_i)
      OP_SHL:  c_next_o = msb_out;
      OP_SHR:  c_next_o = lsb_out;
      OP_BLD:  c_next_o = sel_bit;
      OP_BAND: c_next_o = c_q_i & sel_bit;
      OP_BOR:  c_next_o = c_q_i | sel_bit;
      OP_BXOR: c_next_o = c_q_i ^ sel_bit;
      default: c_next_o = c_q_i;
    endcase
  end
endmodule

// File: rtl/ccr_mask_ops.sv
module ccr_mask_ops
  import ccr_pkg::*;
(
  input  ccr_op_e          op_i,
  input  logic [CCR_W-1:0] ccr_q_i,
  input  logic [CCR_W-1:0] imm_i,
  output logic [CCR_W-1:0] ccr_new_o
);
  always_comb begin
    unique case (op_i)
      OP_LDC:  ccr_new_o = imm_i;
      OP_ANDC: ccr_new_o = ccr_q_i & imm_i;
      OP_ORC:  ccr_new_o = ccr_q_i | imm_i;
      OP_XORC: ccr_new_o = ccr_q_i ^ imm_i;
      default: ccr_new_o = ccr_q_i;
    endcase
  end
endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
  import ccr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      op_valid_i,
  input  logic [4:0]                op_code_i,
  input  logic                      op_word_i,
  input  logic [DATA_W-1:0]         opnd_a_i,
  input  logic [DATA_W-1:0]         opnd_b_i,
  input  logic [DATA_W-1:0]         result_i,
  input  logic [CCR_W-1:0]          imm_i,
  input  logic [$clog2(DATA_W)-1:0] bit_sel_i,
  output logic [CCR_W-1:0]          ccr_o,
  output logic                      flag_i_o,
  output logic                      flag_n_o,
  output logic                      flag_z_o,
  output logic                      flag_v_o,
  output logic                      flag_c_o
);
  localparam int B_MSB = BYTE_W - 1;

  ccr_op_e          op;
  logic             arith_w, shift_w, bit_w, mask_w, upd_w;
  logic             is_sub_w, is_neg_w;
  arith_flags_t     af;
  logic             c_next;
  logic [CCR_W-1:0] mask_val, nxt, ccr_q;
  logic             i_q;
  logic [CCR_W-2:0] lo_q;

  assign op = ccr_op_e'(op_code_i);

  // operation classes, brought out for the assertions
  always_comb begin
    arith_w = 1'b0; shift_w = 1'b0; bit_w = 1'b0; mask_w = 1'b0;
    is_sub_w = 1'b0; is_neg_w = 1'b0;
    unique case (op)
      OP_ADD, OP_ADDX:           arith_w = 1'b1;
      OP_SUB, OP_SUBX, OP_CMP: begin arith_w = 1'b1; is_sub_w = 1'b1; end
      OP_NEG:            begin arith_w = 1'b1; is_sub_w = 1'b1; is_neg_w = 1'b1; end
      OP_SHL, OP_SHR:            shift_w = 1'b1;
      OP_BLD, OP_BAND, OP_BOR, OP_BXOR: bit_w = 1'b1;
      OP_LDC, OP_ANDC, OP_ORC, OP_XORC: mask_w = 1'b1;
      default: ;
    endcase
  end

  assign upd_w = op_valid_i & rst_n & (arith_w | shift_w | bit_w | mask_w);

  ccr_arith_flags #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .NIB_W(NIB_W)) u_arith (
    .op_word_i (op_word_i),
    .is_sub_i  (is_sub_w),
    .is_neg_i  (is_neg_w),
    .opnd_a_i  (opnd_a_i),
    .opnd_b_i  (opnd_b_i),
    .result_i  (result_i),
    .flags_o   (af)
  );

  ccr_carry_path #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_cpath (
    .op_i      (op),
    .op_word_i (op_word_i),
    .opnd_a_i  (opnd_a_i),
    .bit_sel_i (bit_sel_i),
    .c_q_i     (ccr_q[POS_C]),
    .c_next_o  (c_next)
  );

  ccr_mask_ops u_mask (
    .op_i      (op),
    .ccr_q_i   (ccr_q),
    .imm_i     (imm_i),
    .ccr_new_o (mask_val)
  );

  always_comb begin
    nxt = ccr_q;
    if (arith_w) begin
      nxt[POS_H] = af.h;
      nxt[POS_N] = af.n;
      nxt[POS_Z] = af.z;
      nxt[POS_V] = af.v;
      nxt[POS_C] = af.c;
    end else if (shift_w) begin
      nxt[POS_N] = af.n;
      nxt[POS_Z] = af.z;
      nxt[POS_V] = 1'b0;
      nxt[POS_C] = c_next;
    end else if (bit_w) begin
      nxt[POS_C] = c_next;
    end else if (mask_w) begin
      nxt = mask_val;
    end
  end

  // only the interrupt mask has a reset value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     i_q <= 1'b1;
    else if (upd_w) i_q <= nxt[POS_I];
  end

  always_ff @(posedge clk) begin
    if (upd_w) lo_q <= nxt[CCR_W-2:0];
  end

  assign ccr_q    = {i_q, lo_q};
  assign ccr_o    = ccr_q;
  assign flag_i_o = ccr_q[POS_I];
  assign flag_n_o = ccr_q[POS_N];
  assign flag_z_o = ccr_q[POS_Z];
  assign flag_v_o = ccr_q[POS_V];
  assign flag_c_o = ccr_q[POS_C];

  // R1: reset forces the interrupt mask
  a_r1_reset_sets_i: assert property (@(posedge clk) !rst_n |=> flag_i_o);

  // R10: storage bits move only under whole-register operations
  a_r10_user_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid_i && mask_w) |=> (ccr_o[POS_UI] == $past(ccr_o[POS_UI]) &&
                                  ccr_o[POS_U]  == $past(ccr_o[POS_U])));

  // R8: bit operations touch only the carry
  a_r8_bitop_only_c: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && bit_w) |=> (ccr_o[CCR_W-1:1] == $past(ccr_o[CCR_W-1:1])));

  // R7: shifts clear overflow
  a_r7_shift_clears_v: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && shift_w) |=> !flag_v_o);

  // R4: zero flag after arithmetic tracks the presented result
  a_r4_zero_tracks_result: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && arith_w) |=>
      (flag_z_o == $past(op_word_i ? (result_i == '0) : (result_i[B_MSB:0] == '0))));

  // R9: load writes the immediate verbatim
  a_r9_load_whole: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && op == OP_LDC) |=> (ccr_o == $past(imm_i)));
endmodule

// File: tb/tb_ccr_unit.sv
module tb_ccr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid_i = 1'b0;
  logic [4:0]  op_code_i = '0;
  logic        op_word_i = 1'b0;
  logic [15:0] opnd_a_i = '0, opnd_b_i = '0, result_i = '0;
  logic [7:0]  imm_i = '0;
  logic [3:0]  bit_sel_i = '0;
  logic [7:0]  ccr_o;
  logic        flag_i_o, flag_n_o, flag_z_o, flag_v_o, flag_c_o;

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_cc;
  int unsigned seed = 32'd20240611;

  always #5 clk = ~clk;

  ccr_unit dut (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_code_i(op_code_i),
    .op_word_i(op_word_i), .opnd_a_i(opnd_a_i), .opnd_b_i(opnd_b_i),
    .result_i(result_i), .imm_i(imm_i), .bit_sel_i(bit_sel_i), .ccr_o(ccr_o),
    .flag_i_o(flag_i_o), .flag_n_o(flag_n_o), .flag_z_o(flag_z_o),
    .flag_v_o(flag_v_o), .flag_c_o(flag_c_o)
  );

  task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input int op, input bit word, input bit vld);
    if (!vld || op == 0 || op > 16) return "R10";
    if (op <= 6) return word ? "R3/R5/R6" : "R2/R4/R5/R6";
    if (op <= 8) return "R7/R4";
    if (op <= 12) return "R8";
    return "R9";
  endfunction

  function automatic int sgn(input int x, input int w);
    return (x >= (1 << (w - 1))) ? x - (1 << w) : x;
  endfunction

  // arithmetic flags computed by wide integer sums
  function automatic logic [7:0] exp_arith(input bit sub, input bit word, input int a,
                                           input int b, input int cin, input logic [7:0] cc);
    int w, m, hm, r, full, lo, sv;
    logic [7:0] o;
    w = word ? 16 : 8; m = (1 << w) - 1; hm = word ? 'hFFF : 'hF;
    a = a & m; b = b & m; o = cc;
    if (!sub) begin
      full = a + b + cin; lo = (a & hm) + (b & hm) + cin;
      o[5] = lo > hm; o[0] = full > m; sv = sgn(a, w) + sgn(b, w) + cin;
    end else begin
      full = a - b - cin; o[5] = (a & hm) < ((b & hm) + cin); o[0] = a < (b + cin);
      sv = sgn(a, w) - sgn(b, w) - cin;
    end
    r = full & m;
    o[3] = (r >> (w - 1)) & 1;
    o[2] = (r == 0);
    o[1] = (sv >= (1 << (w - 1))) || (sv < -(1 << (w - 1)));
    return o;
  endfunction

  function automatic logic [15:0] make_result(input int op, input bit word, input int a,
                                              input int b, input int c);
    int m;
    m = word ? 'hFFFF : 'hFF;
    a = a & m; b = b & m;
    case (op)
      1: return 16'((a + b) & m);
      2: return 16'((a + b + c) & m);
      3, 5: return 16'((a - b) & m);
      4: return 16'((a - b - c) & m);
      6: return 16'((0 - a) & m);
      7: return 16'((a << 1) & m);
      8: return 16'(a >> 1);
      default: return 16'(a ^ b);
    endcase
  endfunction

  function automatic logic [7:0] model(input int op, input bit vld, input bit word,
                                       input int a, input int b, input int r, input int imm,
                                       input int sel, input logic [7:0] cc);
    logic [7:0] o;
    int w, bt;
    o = cc; w = word ? 16 : 8; bt = (a >> sel) & 1;
    if (!vld) return o;
    case (op)
      1: o = exp_arith(0, word, a, b, 0, cc);
      2: o = exp_arith(0, word, a, b, int'(cc[0]), cc);
      3, 5: o = exp_arith(1, word, a, b, 0, cc);
      4: o = exp_arith(1, word, a, b, int'(cc[0]), cc);
      6: o = exp_arith(1, word, 0, a, 0, cc);
      7, 8: begin
        o[3] = (r >> (w - 1)) & 1;
        o[2] = ((r & ((1 << w) - 1)) == 0);
        o[1] = 1'b0;
        o[0] = (op == 7) ? 1'((a >> (w - 1)) & 1) : 1'(a & 1);
      end
      9:  o[0] = 1'(bt);
      10: o[0] = cc[0] & 1'(bt);
      11: o[0] = cc[0] | 1'(bt);
      12: o[0] = cc[0] ^ 1'(bt);
      13: o = 8'(imm);
      14: o = cc & 8'(imm);
      15: o = cc | 8'(imm);
      16: o = cc ^ 8'(imm);
      default: ;
    endcase
    return o;
  endfunction

  task automatic do_op(input int op, input bit vld, input bit word, input int a,
                       input int b, input int imm, input int sel);
    logic [15:0] r;
    r = make_result(op, word, a, b, int'(exp_cc[0]));
    @(negedge clk);
    op_valid_i = vld; op_code_i = 5'(op); op_word_i = word;
    opnd_a_i = 16'(a); opnd_b_i = 16'(b); result_i = r;
    imm_i = 8'(imm); bit_sel_i = 4'(sel);
    exp_cc = model(op, vld, word, a, b, int'(r), imm, sel, exp_cc);
    @(posedge clk); #1;
    op_valid_i = 1'b0;
    check(tag_of(op, word, vld),
          {ccr_o, flag_i_o, flag_n_o, flag_z_o, flag_v_o, flag_c_o},
          {exp_cc, exp_cc[7], exp_cc[3], exp_cc[2], exp_cc[1], exp_cc[0]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    exp_cc = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", {12'd0, flag_i_o}, 13'd1);   // R1: I set in reset
    @(negedge clk); rst_n = 1'b1;
    // R9: establish a known register
    do_op(13, 1, 0, 0, 0, 'h00, 0);
    // R2 directed byte half-carry / carry / overflow
    do_op(1, 1, 0, 'h0F, 'h01, 0, 0);        // H only
    do_op(1, 1, 0, 'hFF, 'h01, 0, 0);        // H,Z,C
    do_op(1, 1, 0, 'h7F, 'h01, 0, 0);        // R5 V,N,H
    do_op(3, 1, 0, 'h10, 'h01, 0, 0);        // R2 borrow from bit 3
    do_op(3, 1, 0, 'h00, 'h01, 0, 0);        // R6 borrow out of MSB
    do_op(6, 1, 0, 'h80, 0, 0, 0);           // R5 negate of 0x80
    do_op(4, 1, 0, 'h80, 'h00, 0, 0);        // R4 subtract with borrow in
    // R3 word forms
    do_op(1, 1, 1, 'h0FFF, 'h0001, 0, 0);    // H from bit 11
    do_op(1, 1, 1, 'h7FFF, 'h0001, 0, 0);    // V,N at bit 15
    do_op(1, 1, 1, 'hFFFF, 'h0001, 0, 0);    // Z,C word
    do_op(5, 1, 1, 'h1000, 'h0001, 0, 0);    // compare borrow from bit 11
    do_op(1, 1, 1, 'h000F, 'h0001, 0, 0);    // word: bit-3 carry gives no H
    // R7 shifts
    do_op(7, 1, 0, 'h80, 0, 0, 0);
    do_op(8, 1, 1, 'h0001, 0, 0, 0);
    do_op(7, 1, 1, 'h4000, 0, 0, 0);
    // R8 bit accumulator
    do_op(9, 1, 0, 'h8000, 0, 0, 15);
    do_op(10, 1, 0, 'h0000, 0, 0, 3);
    do_op(11, 1, 0, 'h0020, 0, 0, 5);
    do_op(12, 1, 0, 'h0020, 0, 0, 5);
    // R9 mask operations
    do_op(13, 1, 0, 0, 0, 'h5A, 0);
    do_op(15, 1, 0, 0, 0, 'h81, 0);
    do_op(14, 1, 0, 0, 0, 'h3C, 0);
    do_op(16, 1, 0, 0, 0, 'hFF, 0);
    // R10 ignored cycles
    do_op(13, 0, 0, 0, 0, 'h00, 0);
    do_op(0, 1, 0, 'h1234, 'h5678, 'h00, 0);
    do_op(21, 1, 0, 0, 0, 'h00, 0);
    // R1 reset mid-run keeps bits 6..0
    do_op(13, 1, 0, 0, 0, 'h5A, 0);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    check("R1", {ccr_o, 5'd0}, {8'hDA, 5'd0});
    @(negedge clk); rst_n = 1'b1;
    exp_cc = 8'hDA;
    // random mix
    for (int k = 0; k < 400; k++) begin
      int op;
      bit vld, word;
      op   = int'($urandom(seed) % 18);
      vld  = ($urandom(seed) % 10) != 0;
      word = 1'($urandom(seed));
      seed = seed + 32'd7;
      do_op(op, vld, word, int'($urandom(seed) & 'hFFFF), int'($urandom(seed) & 'hFFFF),
            int'($urandom(seed) & 'hFF), int'($urandom(seed) & 'hF));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule